// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and a calendar in binary-coded decimal: seconds, minutes, hours, day of month, weekday, month and a two-digit year that stands for 2000 to 2099. An internal prescaler divides the system clock down to one tick per second. Each tick advances the seconds, and a carry ripples through minutes, hours, days, months and years. The day count follows each month's length, and February gains a 29th day in leap years.

Software reads and writes the counters through a byte-wide register port. The read path is combinational, and a write lands on the clock edge that samples it. A control register holds three things: a 12-hour display mode, a stop bit that freezes counting, and a self-clearing software reset. Bit 7 of the seconds register is a sticky integrity flag. An oscillator-failure input sets it, and only software can clear it.

Top module: `rtc_calendar`

## Requirements
- R1: Register addresses are: control 0x0, seconds 0x3, minutes 0x4, hours 0x5, day 0x6, weekday 0x7, month 0x8, year 0x9. After reset they read 0x00, 0x80, 0x00, 0x00, 0x01, 0x00, 0x01 and 0x00 in that order, so the integrity flag starts set.
- R2: Seconds advance once every CLK_PER_SEC clock cycles. A write to any time register (0x3 to 0x9) restarts the prescaler, so the next advance comes exactly CLK_PER_SEC cycles after the write edge.
- R3: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours (stored 24-hour) wrap from 23 to 00 and advance the day.
- R4: Day 30 is the last day of April, June, September and November, and day 31 is the last day of the other months except February. The day after the last day is 01, and the month then advances.
- R5: February ends on day 29 when the binary year value is divisible by 4 (year 00 included) and on day 28 otherwise.
- R6: Month 12 rolls over to 01 and the year advances. Year 99 rolls over to 00.
- R7: The weekday counts 0 to 6, advances on each day rollover, and wraps from 6 to 0.
- R8: While control bit 5 (stop) is set, nothing advances. After it is cleared, the first advance comes CLK_PER_SEC cycles later.
- R9: Seconds bit 7 is an integrity flag. It is set by reset and by a high osc_fail on any cycle. It stays set until a seconds write with bit 7 at 0, and a seconds write with bit 7 at 1 sets it.
- R10: With control bit 3 set, the hour reads and writes in 12-hour form: BCD 01 to 12 in bits 4:0 and PM in bit 5. Hour 00 appears as 0x12 (12 AM), and 12 PM written as 0x32 reads 0x12 in 24-hour mode.
- R11: In 12-hour mode, 11:59:59 AM (hour 0x11) advances to 12 PM (0x32). 11:59:59 PM (0x31) advances to 12 AM (0x12) and moves to the next day.
- R12: A control write with bit 4 set restores every register to its R1 value on that edge. Control bit 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_fail | input | 1 | Oscillator failure event; sets the integrity flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the addressed register |

## Verification
A register write takes effect on the edge that samples it, so its read-back is checked at the following falling edge. The prescaler restarts on that same edge, so a counted advance is due exactly CLK_PER_SEC rising edges after the write or after the stop bit clears. The bench waits that exact number of rising edges and reads at the next falling edge. It also samples one edge earlier to show that nothing has moved yet. An osc_fail pulse and a software reset take effect on the edge that samples them and are checked at the falling edge right after.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'h3;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'h4;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'h5;
  localparam logic [ADDR_W-1:0] A_DAY  = 4'h6;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'h7;
  localparam logic [ADDR_W-1:0] A_MON  = 4'h8;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'h9;
  localparam int B_MODE12 = 3;
  localparam int B_SWRST  = 4;
  localparam int B_STOP   = 5;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;   // always held in 24-hour BCD
    logic [5:0] day;
    logic [2:0] wday;
    logic [4:0] mon;
    logic [7:0] year;
  } cal_time_t;

  localparam cal_time_t TIME_RST = '{sec: 7'h00, min: 7'h00, hour: 6'h00,
                                     day: 6'h01, wday: 3'd0, mon: 5'h01, year: 8'h00};

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    return bin2bcd(bcd2bin(b) + 7'd1);
  endfunction

  // last valid day of a month, as BCD
  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
    logic [6:0] y;
    y = bcd2bin(yr);
    case (mon)
      5'h02:                      return (y[1:0] == 2'b00) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  // 24-hour BCD -> 12-hour register image (PM in bit 5)
  function automatic logic [7:0] hr24_to_12(input logic [5:0] h);
    logic [6:0] b;
    logic [7:0] t;
    logic       pm;
    b  = bcd2bin({2'b00, h});
    pm = (b >= 7'd12);
    if (pm) b = b - 7'd12;
    if (b == 7'd0) b = 7'd12;
    t = bin2bcd(b);
    return {2'b00, pm, t[4:0]};
  endfunction

  // 12-hour register image -> 24-hour BCD
  function automatic logic [5:0] hr12_to_24(input logic [7:0] r);
    logic [6:0] b;
    logic [7:0] t;
    b = bcd2bin({3'b000, r[4:0]});
    if (b == 7'd12) b = 7'd0;
    if (r[5]) b = b + 7'd12;
    t = bin2bcd(b);
    return t[5:0];
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int CLK_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLK_PER_SEC > 2) ? $clog2(CLK_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = at_last && !stop && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (stop || restart)    cnt_q <= '0;
    else if (at_last)            cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
(
  input  cal_time_t cur,
  output cal_time_t nxt,
  output logic      day_wrap
);
  logic       sec_wrap, min_wrap, hr_wrap, mon_wrap;
  logic [5:0] last;

  assign last     = last_day(cur.mon, cur.year);
  assign sec_wrap = (cur.sec == 7'h59);
  assign min_wrap = sec_wrap && (cur.min == 7'h59);
  assign hr_wrap  = min_wrap && (cur.hour == 6'h23);
  assign day_wrap = hr_wrap && (cur.day == last);
  assign mon_wrap = day_wrap && (cur.mon == 5'h12);

  always_comb begin
    nxt      = cur;
    nxt.sec  = sec_wrap ? 7'h00 : 7'(bcd_inc({1'b0, cur.sec}));
    if (sec_wrap) nxt.min  = min_wrap ? 7'h00 : 7'(bcd_inc({1'b0, cur.min}));
    if (min_wrap) nxt.hour = hr_wrap ? 6'h00 : 6'(bcd_inc({2'b00, cur.hour}));
    if (hr_wrap) begin
      nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
      nxt.day  = day_wrap ? 6'h01 : 6'(bcd_inc({2'b00, cur.day}));
    end
    if (day_wrap) nxt.mon  = mon_wrap ? 5'h01 : 5'(bcd_inc({3'b000, cur.mon}));
    if (mon_wrap) nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import cal_pkg::*;
#(
  parameter int CLK_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_fail,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  cal_time_t t_q, t_adv;
  logic      flag_q, mode12_q, stop_q;
  logic      sel_time, sw_rst, restart, tick, day_wrap;

  assign sel_time = reg_we && (reg_addr >= A_SEC) && (reg_addr <= A_YEAR);
  assign sw_rst   = reg_we && (reg_addr == A_CTRL) && reg_wdata[B_SWRST];
  assign restart  = sel_time || sw_rst;

  cal_prescaler #(.CLK_PER_SEC(CLK_PER_SEC)) presc_i (
    .clk(clk), .rst_n(rst_n), .stop(stop_q), .restart(restart), .tick(tick));

  cal_advance adv_i (.cur(t_q), .nxt(t_adv), .day_wrap(day_wrap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q      <= TIME_RST;
      flag_q   <= 1'b1;
      mode12_q <= 1'b0;
      stop_q   <= 1'b0;
    end else if (sw_rst) begin
      t_q      <= TIME_RST;
      flag_q   <= 1'b1;
      mode12_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      if (tick) t_q <= t_adv;
      flag_q <= ((reg_we && reg_addr == A_SEC) ? reg_wdata[7] : flag_q) | osc_fail;
      if (reg_we) begin
        case (reg_addr)
          A_CTRL: begin
            mode12_q <= reg_wdata[B_MODE12];
            stop_q   <= reg_wdata[B_STOP];
          end
          A_SEC:  t_q.sec  <= reg_wdata[6:0];
          A_MIN:  t_q.min  <= reg_wdata[6:0];
          A_HOUR: t_q.hour <= mode12_q ? hr12_to_24(reg_wdata) : reg_wdata[5:0];
          A_DAY:  t_q.day  <= reg_wdata[5:0];
          A_WDAY: t_q.wday <= reg_wdata[2:0];
          A_MON:  t_q.mon  <= reg_wdata[4:0];
          A_YEAR: t_q.year <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {2'b00, stop_q, 1'b0, mode12_q, 3'b000};
      A_SEC:   reg_rdata = {flag_q, t_q.sec};
      A_MIN:   reg_rdata = {1'b0, t_q.min};
      A_HOUR:  reg_rdata = mode12_q ? hr24_to_12(t_q.hour) : {2'b00, t_q.hour};
      A_DAY:   reg_rdata = {2'b00, t_q.day};
      A_WDAY:  reg_rdata = {5'b00000, t_q.wday};
      A_MON:   reg_rdata = {3'b000, t_q.mon};
      A_YEAR:  reg_rdata = t_q.year;
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import cal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              stop,
  input logic              restart,
  input logic              day_wrap,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wbit7,
  input logic              osc_fail,
  input logic              flag,
  input logic [6:0]        sec,
  input logic [6:0]        min,
  input logic [5:0]        hour
);
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !tick); // R2

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !tick); // R8

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reg_we) |=> ($stable(sec) && $stable(min) && $stable(hour))); // R2

  AST_MIDNIGHT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hour == 6'h23 && min == 7'h59 && sec == 7'h59) |=> (hour == 6'h00 && min == 7'h00 && sec == 7'h00)); // R3

  AST_DAYWRAP_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    day_wrap |-> (hour == 6'h23 && min == 7'h59 && sec == 7'h59)); // R4

  AST_FLAG_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> flag); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(reg_we && reg_addr == A_SEC && !wbit7)) |=> flag); // R9
endmodule

bind rtc_calendar rtc_calendar_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop_q), .restart(restart),
  .day_wrap(day_wrap), .reg_we(reg_we), .reg_addr(reg_addr), .wbit7(reg_wdata[7]),
  .osc_fail(osc_fail), .flag(flag_q), .sec(t_q.sec), .min(t_q.min), .hour(t_q.hour));

// File: tb/rtc_calendar_tb_top.sv
module rtc_calendar_tb_top;
  localparam int N = 4;
  localparam int NVEC = 11;
  // {sec,min,hour,day,wday,mon,year} start, then expected after one second
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h00_00_00_01_00_01_00, 56'h01_00_00_01_00_01_00},  // R2
    {56'h59_20_10_15_02_07_18, 56'h00_21_10_15_02_07_18},  // R3
    {56'h59_59_10_15_02_07_18, 56'h00_00_11_15_02_07_18},  // R3
    {56'h59_59_23_31_06_01_24, 56'h00_00_00_01_00_02_24},  // R4 R7
    {56'h59_59_23_28_03_02_24, 56'h00_00_00_29_04_02_24},  // R5
    {56'h59_59_23_29_04_02_24, 56'h00_00_00_01_05_03_24},  // R5
    {56'h59_59_23_28_01_02_23, 56'h00_00_00_01_02_03_23},  // R5
    {56'h59_59_23_30_01_04_23, 56'h00_00_00_01_02_05_23},  // R4
    {56'h59_59_23_30_01_05_23, 56'h00_00_00_31_02_05_23},  // R4
    {56'h59_59_23_31_03_12_99, 56'h00_00_00_01_04_01_00},  // R6
    {56'h59_59_23_28_05_02_00, 56'h00_00_00_29_06_02_00}   // R5
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_fail = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rtc_calendar #(.CLK_PER_SEC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_fail(osc_fail), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // caller is away from a clock edge; write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_time(input logic [55:0] t);
    @(negedge clk);
    wr(4'h9, t[7:0]);   wr(4'h8, t[15:8]);  wr(4'h7, t[23:16]);
    wr(4'h6, t[31:24]); wr(4'h5, t[39:32]); wr(4'h4, t[47:40]);
    wr(4'h3, t[55:48]);
  endtask

  task automatic get_time(output logic [55:0] t);
    @(negedge clk);
    rd(4'h3, t[55:48]); rd(4'h4, t[47:40]); rd(4'h5, t[39:32]);
    rd(4'h6, t[31:24]); rd(4'h7, t[23:16]); rd(4'h8, t[15:8]);
    rd(4'h9, t[7:0]);
  endtask

  task automatic get_all(output logic [63:0] t);
    logic [55:0] tm;
    logic [7:0]  c;
    get_time(tm);
    rd(4'h0, c);
    t = {c, tm};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [55:0] t;
    logic [63:0] all;
    logic [7:0]  b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    get_all(all);
    chk("R1 reset values", all, 64'h00_80_00_00_01_00_01_00);

    foreach (VEC[i]) begin
      set_time(VEC[i][111:56]);
      repeat (N) @(posedge clk);
      get_time(t);
      chk($sformatf("R3/R4/R5/R6/R7 vector %0d", i), {8'h00, t}, {8'h00, VEC[i][55:0]});
    end

    // R2 prescaler restart on a write in mid-second
    set_time(56'h10_00_00_01_00_01_00);
    repeat (N - 1) @(posedge clk);
    @(negedge clk); rd(4'h3, b);
    chk("R2 no advance before full second", {56'h0, b}, 64'h10);
    wr(4'h3, 8'h20);
    repeat (N - 1) @(posedge clk);
    @(negedge clk); rd(4'h3, b);
    chk("R2 write restarts prescaler", {56'h0, b}, 64'h20);
    @(posedge clk);
    @(negedge clk); rd(4'h3, b);
    chk("R2 advance one second after write", {56'h0, b}, 64'h21);

    // R8 stop freezes counting
    @(negedge clk);
    wr(4'h0, 8'h20);
    wr(4'h3, 8'h30);
    repeat (3 * N) @(posedge clk);
    @(negedge clk); rd(4'h3, b);
    chk("R8 stopped seconds hold", {56'h0, b}, 64'h30);
    wr(4'h0, 8'h00);
    repeat (N - 1) @(posedge clk);
    @(negedge clk); rd(4'h3, b);
    chk("R8 no advance right after release", {56'h0, b}, 64'h30);
    @(posedge clk);
    @(negedge clk); rd(4'h3, b);
    chk("R8 advance a second after release", {56'h0, b}, 64'h31);

    // R9 integrity flag
    @(negedge clk);
    osc_fail = 1'b1; @(posedge clk); #1 osc_fail = 1'b0;
    @(negedge clk); rd(4'h3, b);
    chk("R9 osc_fail sets flag", {63'h0, b[7]}, 64'h1);
    wr(4'h4, 8'h05);
    repeat (2 * N) @(posedge clk);
    @(negedge clk); rd(4'h3, b);
    chk("R9 flag sticky across time and other writes", {63'h0, b[7]}, 64'h1);
    wr(4'h3, 8'h05);
    @(negedge clk); rd(4'h3, b);
    chk("R9 seconds write with bit7 clear", {56'h0, b}, 64'h05);
    wr(4'h3, 8'h85);
    @(negedge clk); rd(4'h3, b);
    chk("R9 seconds write with bit7 set", {56'h0, b}, 64'h85);
    wr(4'h3, 8'h00);

    // R10 12-hour format
    @(negedge clk);
    wr(4'h5, 8'h00);
    wr(4'h0, 8'h08);
    @(negedge clk); rd(4'h5, b);
    chk("R10 midnight reads 12 AM", {56'h0, b}, 64'h12);
    wr(4'h5, 8'h31);
    wr(4'h0, 8'h00);
    @(negedge clk); rd(4'h5, b);
    chk("R10 11 PM reads 23 in 24h", {56'h0, b}, 64'h23);
    wr(4'h5, 8'h12);
    wr(4'h0, 8'h08);
    wr(4'h5, 8'h32);
    wr(4'h0, 8'h00);
    @(negedge clk); rd(4'h5, b);
    chk("R10 12 PM reads 12 in 24h", {56'h0, b}, 64'h12);

    // R11 12-hour transitions
    @(negedge clk);
    wr(4'h0, 8'h08);
    set_time(56'h59_59_11_05_02_03_24);
    repeat (N) @(posedge clk);
    get_time(t);
    chk("R11 11:59:59 AM to 12 PM", {8'h00, t}, {8'h00, 56'h00_00_32_05_02_03_24});
    set_time(56'h59_59_31_05_02_03_24);
    repeat (N) @(posedge clk);
    get_time(t);
    chk("R11 11:59:59 PM to 12 AM next day", {8'h00, t}, {8'h00, 56'h00_00_12_06_03_03_24});

    // R12 software reset
    @(negedge clk);
    wr(4'h0, 8'h28);
    set_time(56'h33_44_21_17_05_09_42);
    @(negedge clk);
    wr(4'h0, 8'h10);
    get_all(all);
    chk("R12 software reset restores defaults", all, 64'h00_80_00_00_01_00_01_00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule